// File: doc/BRIEF.md
# I2C Controller Enable and Selective Soft-Reset Unit

This unit owns the enable bit of an I2C controller's register set and turns a software clear of that bit into a selective reset. While the enable bit is low, or while a minimum low interval is still running, the unit releases both open-drain line drivers. It also holds the protocol engine in reset and forces the command bits and status flags to their idle values. The configuration fields are left alone: the filter setup, the stretch-disable bit and the bus timing word. Only a hardware reset returns those to zero.

Software performs the reset in three steps. It clears the enable bit, reads the bit back until it shows 0, and then sets it again. The unit counts bus clocks from the clearing write. If software sets the bit again too early, the unit keeps its internal reset asserted until the minimum interval of `MIN_HOLD` clocks has elapsed.

The bit-level engine and the timing generator sit outside this unit. Toward this unit they are represented only by line-low requests, flag set and clear strobes, and command-done strobes.

Top module: `i2c_srst_ctrl`

## Requirements
- R1: After hardware reset, every register reads zero except STATUS, which reads 0x0001 (the buffer-empty flag). The enable bit is 0 and `eng_rst_n` is low.
- R2: From the clock edge that takes a write of 0 to enable bit 0 of CTRL (address 0), `scl_oe` and `sda_oe` are both 0, whatever the engine requests.
- R3: `eng_rst_n` is low whenever the enable bit reads 0.
- R4: After a write that clears a set enable bit at edge k, `eng_rst_n` stays low through edge k+MIN_HOLD-1 and rises at edge k+MIN_HOLD, even if enable is written back to 1 at edge k+1.
- R5: While the internal reset is active, command bits START (CMD bit 0, address 1), STOP (bit 1) and NACK (bit 2) read 0, and CMD writes are dropped.
- R6: While the internal reset is active, STATUS (address 3, read-only) reads exactly 0x0001. Bit 0 is buffer-empty (reset value 1). Bits 1 to 10 are transmit-request, receive-full, address-match, nack-seen, stop-seen, transfer-done, reload-pending, bus-error, arbitration-lost and overrun. Bit 14 is busy. Engine set strobes are ignored during this time.
- R7: With the SMBus option enabled (default), the PEC-byte command bit (CMD bit 3) is also cleared by the soft reset. So are the PEC-error, timeout and alert flags (STATUS bits 11, 12, 13).
- R8: The configuration fields keep their values through a soft reset. These are CTRL bits 6:1 (filter length in bits 4:1, analog-filter-off in bit 5, stretch-disable in bit 6) and the TIMING word at address 2 (bits 27:0). Only writes and hardware reset change them.
- R9: A read of CTRL bit 0 returns the last written enable value in the cycle right after the write.
- R10: When enabled, a CMD write sets the bits written as 1, and `eng_cmd_ack` clears bits. For the status flags, `eng_stat_clr` clears a flag and `eng_stat_set` sets one; a set wins over a simultaneous clear.
- R11: When enabled and out of reset, `scl_oe` follows `eng_scl_low` and `sda_oe` follows `eng_sda_low`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Hardware reset, active low |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| eng_scl_low | input | 1 | Engine asks to pull SCL low |
| eng_sda_low | input | 1 | Engine asks to pull SDA low |
| eng_stat_set | input | 15 | Per-flag set strobes from the engine |
| eng_stat_clr | input | 15 | Per-flag clear strobes from the engine |
| eng_cmd_ack | input | 4 | Per-bit command completion strobes |
| scl_oe | output | 1 | SCL open-drain pull-down enable |
| sda_oe | output | 1 | SDA open-drain pull-down enable |
| eng_rst_n | output | 1 | Reset to the protocol engine, active low |
| eng_cmd | output | 4 | Current command bits |
| cfg_misc | output | 6 | Filter, analog-off and stretch-disable settings |
| cfg_timing | output | 28 | Timing word |

## Verification
The soft reset is driven from a fully loaded state, with all command bits and every flag set and both lines pulled low. This separates fields that really clear from fields that only stop updating. It also separates preserved configuration from configuration rewritten by chance. A second pattern re-enables one cycle after the clear and samples `eng_rst_n` on each cycle of the hold window, which exposes an off-by-one in the counter. Writes and engine strobes issued while the unit is disabled show whether the reset dominates. A final hardware reset separates the configuration clear from the soft path.

// File: rtl/i2c_srst_pkg.sv
package i2c_srst_pkg;
   localparam int ADDR_W  = 2;
   localparam int CFG_W   = 6;
   localparam int TIM_W   = 28;
   localparam int CMD_W   = 4;
   localparam int STAT_W  = 15;

   localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
   localparam logic [ADDR_W-1:0] A_CMD  = 2'd1;
   localparam logic [ADDR_W-1:0] A_TIME = 2'd2;
   localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

   localparam int CMD_PECB  = 3;
   localparam int ST_SMB_LO = 11;
   localparam int ST_SMB_N  = 3;

   localparam logic [STAT_W-1:0] STAT_IDLE = 15'h0001;

   function automatic logic [STAT_W-1:0] smb_stat_bits();
      logic [STAT_W-1:0] m;
      m = '0;
      for (int i = 0; i < ST_SMB_N; i++) m[ST_SMB_LO+i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/srst_hold_timer.sv
module srst_hold_timer #(
   parameter int MIN_HOLD = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic hold_done
);
   localparam int CNT_W = $clog2(MIN_HOLD + 1);
   localparam logic [CNT_W-1:0] HOLD_C = CNT_W'(MIN_HOLD);

   if (MIN_HOLD < 1) begin : g_bad_hold
      $error("MIN_HOLD must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (restart)        cnt_q <= '0;
      else if (cnt_q != HOLD_C) cnt_q <= cnt_q + 1'b1;
   end

   assign hold_done = (cnt_q == HOLD_C);

   // R4: the window advances one per clock until complete
   a_r4_hold_advances: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && cnt_q != HOLD_C) |=> (cnt_q == $past(cnt_q) + 1'b1));
   // R4: a restart always reopens the window
   a_r4_restart_opens: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !hold_done);
endmodule

// File: rtl/srst_cfg_bank.sv
module srst_cfg_bank import i2c_srst_pkg::*; (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wen,
   input  logic [ADDR_W-1:0] addr,
   input  logic [TIM_W-1:0]  wdata,
   output logic              en_q,
   output logic [CFG_W-1:0]  misc_q,
   output logic [TIM_W-1:0]  tim_q,
   output logic              en_clear
);
   logic ctrl_wr, tim_wr;
   assign ctrl_wr  = wen && (addr == A_CTRL);
   assign tim_wr   = wen && (addr == A_TIME);
   assign en_clear = ctrl_wr && en_q && !wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         misc_q <= '0;
         tim_q  <= '0;
      end else begin
         if (ctrl_wr) begin
            en_q   <= wdata[0];
            misc_q <= wdata[CFG_W:1];
         end
         if (tim_wr) tim_q <= wdata;
      end
   end

   // R8: timing word changes only by its own write
   a_r8_timing_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !tim_wr |=> $stable(tim_q));
   // R8: configuration bits change only by a CTRL write
   a_r8_misc_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_wr |=> $stable(misc_q));
   // R9: enable reflects the write on the next cycle
   a_r9_en_readback: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (en_q == $past(wdata[0])));
endmodule

// File: rtl/srst_live_regs.sv
module srst_live_regs import i2c_srst_pkg::*; #(
   parameter bit HAS_SMBUS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              cmd_wen,
   input  logic [CMD_W-1:0]  cmd_wdata,
   input  logic [CMD_W-1:0]  cmd_ack,
   input  logic [STAT_W-1:0] stat_set,
   input  logic [STAT_W-1:0] stat_clr,
   output logic [CMD_W-1:0]  cmd_q,
   output logic [STAT_W-1:0] stat_q
);
   logic [CMD_W-1:0]  cmd_keep;
   logic [STAT_W-1:0] stat_keep;

   if (HAS_SMBUS) begin : g_smbus
      assign cmd_keep  = '1;
      assign stat_keep = '1;
   end else begin : g_plain
      logic [CMD_W-1:0] pec_bit;
      always_comb begin
         pec_bit           = '0;
         pec_bit[CMD_PECB] = 1'b1;
      end
      assign cmd_keep  = ~pec_bit;
      assign stat_keep = ~smb_stat_bits();
   end

   logic [CMD_W-1:0]  cmd_set;
   assign cmd_set = cmd_wen ? cmd_wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         stat_q <= STAT_IDLE;
      end else if (soft_rst) begin
         cmd_q  <= '0;
         stat_q <= STAT_IDLE;
      end else begin
         cmd_q  <= ((cmd_q & ~cmd_ack) | cmd_set) & cmd_keep;
         stat_q <= ((stat_q & ~stat_clr) | stat_set) & stat_keep;
      end
   end

   // R5 R7: command bits are cleared during the soft reset
   a_r5_cmd_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (cmd_q == '0));
   // R6 R7: flags sit at their idle pattern during the soft reset
   a_r6_stat_idle: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (stat_q == STAT_IDLE));
   // R10: an acknowledged command bit drops when not rewritten
   a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_wen) |=> ((cmd_q & $past(cmd_ack)) == '0));
endmodule

// File: rtl/i2c_srst_ctrl.sv
module i2c_srst_ctrl import i2c_srst_pkg::*; #(
   parameter int DATA_W    = 32,
   parameter int MIN_HOLD  = 3,
   parameter bit HAS_SMBUS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wen,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              eng_scl_low,
   input  logic              eng_sda_low,
   input  logic [STAT_W-1:0] eng_stat_set,
   input  logic [STAT_W-1:0] eng_stat_clr,
   input  logic [CMD_W-1:0]  eng_cmd_ack,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic              eng_rst_n,
   output logic [CMD_W-1:0]  eng_cmd,
   output logic [CFG_W-1:0]  cfg_misc,
   output logic [TIM_W-1:0]  cfg_timing
);
   if (DATA_W <= TIM_W) begin : g_bad_width
      $error("DATA_W must exceed the timing word width");
   end

   logic              en_q, en_clear, hold_done, soft_rst;
   logic [STAT_W-1:0] stat_q;
   logic              unused_wdata_hi;

   assign unused_wdata_hi = ^reg_wdata[DATA_W-1:TIM_W];

   srst_cfg_bank u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wen      (reg_wen),
      .addr     (reg_addr),
      .wdata    (reg_wdata[TIM_W-1:0]),
      .en_q     (en_q),
      .misc_q   (cfg_misc),
      .tim_q    (cfg_timing),
      .en_clear (en_clear)
   );

   srst_hold_timer #(.MIN_HOLD(MIN_HOLD)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (en_clear),
      .hold_done (hold_done)
   );

   assign soft_rst  = !(en_q && hold_done);
   assign eng_rst_n = !soft_rst;

   srst_live_regs #(.HAS_SMBUS(HAS_SMBUS)) u_live (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (soft_rst),
      .cmd_wen   (reg_wen && (reg_addr == A_CMD)),
      .cmd_wdata (reg_wdata[CMD_W-1:0]),
      .cmd_ack   (eng_cmd_ack),
      .stat_set  (eng_stat_set),
      .stat_clr  (eng_stat_clr),
      .cmd_q     (eng_cmd),
      .stat_q    (stat_q)
   );

   assign scl_oe = eng_rst_n && eng_scl_low;
   assign sda_oe = eng_rst_n && eng_sda_low;

   always_comb begin
      unique case (reg_addr)
         A_CTRL:  reg_rdata = DATA_W'({cfg_misc, en_q});
         A_CMD:   reg_rdata = DATA_W'(eng_cmd);
         A_TIME:  reg_rdata = DATA_W'(cfg_timing);
         default: reg_rdata = DATA_W'(stat_q);
      endcase
   end

   // R2: a clearing write releases both lines on the next cycle
   a_r2_lines_released: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wen && reg_addr == A_CTRL && !reg_wdata[0]) |=> (!scl_oe && !sda_oe));
   // R3: the engine stays in reset while disabled
   a_r3_engine_held: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !eng_rst_n);
   // R4: a clearing write keeps the engine in reset on the next cycle
   a_r4_reset_follows_clear: assert property (@(posedge clk) disable iff (!rst_n)
      en_clear |=> !eng_rst_n);
endmodule

// File: tb/tb_i2c_srst_ctrl.sv
`timescale 1ns/100ps
module tb_i2c_srst_ctrl;
   import i2c_srst_pkg::*;

   localparam int DW = 32;
   localparam int WD_CYCLES = 20000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wen = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [DW-1:0]     reg_wdata = '0;
   logic [DW-1:0]     reg_rdata;
   logic              eng_scl_low = 1'b0, eng_sda_low = 1'b0;
   logic [STAT_W-1:0] eng_stat_set = '0, eng_stat_clr = '0;
   logic [CMD_W-1:0]  eng_cmd_ack = '0;
   logic              scl_oe, sda_oe, eng_rst_n;
   logic [CMD_W-1:0]  eng_cmd;
   logic [CFG_W-1:0]  cfg_misc;
   logic [TIM_W-1:0]  cfg_timing;

   always #2 clk = ~clk;

   i2c_srst_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .eng_scl_low(eng_scl_low), .eng_sda_low(eng_sda_low),
      .eng_stat_set(eng_stat_set), .eng_stat_clr(eng_stat_clr),
      .eng_cmd_ack(eng_cmd_ack), .scl_oe(scl_oe), .sda_oe(sda_oe),
      .eng_rst_n(eng_rst_n), .eng_cmd(eng_cmd), .cfg_misc(cfg_misc),
      .cfg_timing(cfg_timing)
   );

   typedef struct {
      int          sel;
      logic [31:0] exp;
      string       req;
   } sb_item_t;

   sb_item_t sb_q[$];
   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // monitor: pops expected items and compares against the ports
   initial forever begin
      sb_item_t it;
      logic [31:0] act;
      wait (sb_q.size() != 0);
      #0.5;
      it = sb_q.pop_front();
      case (it.sel)
         0:       act = reg_rdata;
         1:       act = {30'd0, scl_oe, sda_oe};
         default: act = {31'd0, eng_rst_n};
      endcase
      n_cmp++;
      if (act !== it.exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", it.req, act, it.exp);
      end
   end

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
      cyc();
      reg_wen = 1'b0;
   endtask

   task automatic expect_item(input int sel, input logic [ADDR_W-1:0] a,
                              input logic [31:0] e, input string req);
      sb_item_t it;
      reg_addr = a;
      it.sel = sel; it.exp = e; it.req = req;
      sb_q.push_back(it);
      #1;
   endtask

   task automatic strobe(input logic [STAT_W-1:0] s, input logic [STAT_W-1:0] c,
                         input logic [CMD_W-1:0] k);
      eng_stat_set = s; eng_stat_clr = c; eng_cmd_ack = k;
      cyc();
      eng_stat_set = '0; eng_stat_clr = '0; eng_cmd_ack = '0;
   endtask

   task automatic hw_reset();
      rst_n = 1'b0;
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
   endtask

   localparam logic [31:0] TIM_V  = 32'h0ABC_DEF5;
   localparam logic [31:0] CTRL_ON  = 32'h5B;
   localparam logic [31:0] CTRL_OFF = 32'h5A;

   initial begin
      cyc();
      hw_reset();
      // R1: reset state
      expect_item(0, A_CTRL, 32'h0,    "R1 ctrl after reset");
      expect_item(0, A_CMD,  32'h0,    "R1 cmd after reset");
      expect_item(0, A_TIME, 32'h0,    "R1 timing after reset");
      expect_item(0, A_STAT, 32'h1,    "R1 status after reset");
      expect_item(2, A_CTRL, 32'h0,    "R1 R3 engine reset while disabled");

      // configuration with enable low, then enable
      wr(A_TIME, TIM_V);
      wr(A_CTRL, CTRL_ON);
      expect_item(0, A_CTRL, CTRL_ON,  "R9 enable reads back 1");
      expect_item(2, A_CTRL, 32'h1,    "R3 engine released once enabled");

      // R11: line pass-through
      eng_scl_low = 1'b1; eng_sda_low = 1'b0;
      expect_item(1, A_CTRL, 32'h2,    "R11 scl low only");
      eng_sda_low = 1'b1;
      expect_item(1, A_CTRL, 32'h3,    "R11 both lines low");

      // R10: command set and ack
      wr(A_CMD, 32'h7);
      expect_item(0, A_CMD, 32'h7,     "R10 cmd write sets");
      strobe('0, '0, 4'h2);
      expect_item(0, A_CMD, 32'h5,     "R10 ack clears stop");
      wr(A_CMD, 32'h8);
      expect_item(0, A_CMD, 32'hD,     "R10 R7 pec byte set");

      // R10: flags
      strobe(15'h7FFE, '0, '0);
      expect_item(0, A_STAT, 32'h7FFF, "R10 all flags set");
      strobe(15'h0001, 15'h0001, '0);
      expect_item(0, A_STAT, 32'h7FFF, "R10 set beats clear");
      strobe('0, 15'h0001, '0);
      expect_item(0, A_STAT, 32'h7FFE, "R10 clear strobe");

      // soft reset from a loaded state
      wr(A_CTRL, CTRL_OFF);
      expect_item(0, A_CTRL, CTRL_OFF, "R9 R8 enable reads 0 next cycle");
      expect_item(1, A_CTRL, 32'h0,    "R2 lines released");
      expect_item(2, A_CTRL, 32'h0,    "R3 engine held");
      expect_item(0, A_CMD,  32'h0,    "R5 R7 commands cleared");
      expect_item(0, A_STAT, 32'h1,    "R6 R7 flags idle");
      expect_item(0, A_TIME, TIM_V,    "R8 timing kept");

      // stimulus while disabled is dropped
      wr(A_CMD, 32'hF);
      expect_item(0, A_CMD, 32'h0,     "R5 cmd write ignored while disabled");
      strobe(15'h7FFE, '0, '0);
      expect_item(0, A_STAT, 32'h1,    "R6 flag sets ignored while disabled");
      repeat (5) cyc();
      expect_item(2, A_CTRL, 32'h0,    "R3 engine held while enable low");

      // R4: early re-enable extends the hold
      wr(A_CTRL, CTRL_ON);
      expect_item(2, A_CTRL, 32'h1,    "R4 re-enable after long low");
      wr(A_CTRL, CTRL_OFF);
      wr(A_CTRL, CTRL_ON);
      expect_item(0, A_CTRL, CTRL_ON,  "R9 enable reads 1 again");
      expect_item(2, A_CTRL, 32'h0,    "R4 hold cycle 2");
      expect_item(1, A_CTRL, 32'h0,    "R4 R2 lines released in hold");
      cyc();
      expect_item(2, A_CTRL, 32'h0,    "R4 hold cycle 3");
      cyc();
      expect_item(2, A_CTRL, 32'h1,    "R4 engine released after hold");
      expect_item(1, A_CTRL, 32'h3,    "R11 lines follow again");

      // R1 R8: hardware reset clears configuration
      hw_reset();
      expect_item(0, A_TIME, 32'h0,    "R1 R8 timing cleared by hw reset");
      expect_item(0, A_CTRL, 32'h0,    "R1 R8 ctrl cleared by hw reset");

      wait (sb_q.size() == 0);
      #1;
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(WD_CYCLES * 4);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule